// File: doc/BRIEF.md
# Maskable interrupt flag controller

This block keeps the interrupt request state that sits between a set of peripheral request lines and the core's dispatcher. Each request line is watched for a low-to-high transition, which latches a flag bit. Software can read and overwrite the flags and a per-line enable mask through a small address/data port. A hidden master enable gates all servicing. From the flags, the mask and the master enable, the block presents a pending indication and the index of the request that should be serviced next.

The core supplies decoded single-cycle pulses for three commands: enable-interrupts, disable-interrupts and return-from-interrupt. It also supplies a strobe at every instruction boundary. The enable-interrupts command takes effect only after the instruction that follows it has completed; return-from-interrupt takes effect at once. When the dispatcher accepts an interrupt it pulses an acknowledge. This clears the serviced flag and drops the master enable, so the handler runs with further servicing blocked until software re-enables it.

Top module: `irqc_top`

## Requirements
- R1: A rising edge on request line i sets flag bit i one clock later. A line that stays high does not set the bit again after the bit has been cleared.
- R2: The pending output is 1 only when the master enable is 1 and at least one bit is set in both the flag and enable registers. A request that is not serviceable stays latched until it becomes serviceable.
- R3: The index output gives the lowest-numbered bit that is set in both the flag and enable registers, as a binary number (bit 0 is the most urgent).
- R4: After an enable-interrupts pulse, the master enable becomes 1 only at the second instruction-boundary strobe, counting a strobe in the same cycle as the pulse. A disable-interrupts pulse at or before that strobe cancels it, so no interrupt is ever pending in between.
- R5: A return-from-interrupt pulse sets the master enable on the next clock, with no boundary needed.
- R6: After reset the master enable, the flags and the enable mask are all 0. No address reads back the master enable: reads return the same data whatever its value.
- R7: A write to address 0xFF0F replaces the flag bits with the low data bits, which raises or discards requests. Raised requests are still gated as in R2.
- R8: An acknowledge while pending clears the flag bit named by the index output and clears the master enable.
- R9: A rising edge in the same cycle as a write or an acknowledge that would clear the same bit leaves the bit set.
- R10: Reading 0xFF0F returns the flags in bits 4..0 with bits 7..5 as 1. Reading 0xFFFF returns the mask in bits 4..0 with bits 7..5 as 0. Any other address reads 0, and a write to 0xFFFF stores only bits 4..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Peripheral request lines |
| bus_addr_i | input | 16 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational from address) |
| cmd_ei_i | input | 1 | Enable-interrupts command pulse |
| cmd_di_i | input | 1 | Disable-interrupts command pulse |
| cmd_reti_i | input | 1 | Return-from-interrupt command pulse |
| insn_done_i | input | 1 | Instruction-boundary strobe |
| ack_i | input | 1 | Dispatcher acknowledge |
| irq_pending_o | output | 1 | An interrupt is serviceable |
| irq_index_o | output | 3 | Index of the interrupt to service |

## Verification
The bench builds the block with its default parameters: five request lines, an 8-bit data port and the flag and mask registers at 0xFF0F and 0xFFFF. With these values every priority ordering among the five bits can be reached, as can both padding patterns of the read data. The bench also covers the collisions between an edge and a clearing write or acknowledge. It steps the deferred enable strobe by strobe, including the case where the strobe and the command arrive in the same cycle, and the case where a disable cancels the enable.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    EI_IDLE      = 2'b00,
    EI_WAIT_OWN  = 2'b01,
    EI_WAIT_NEXT = 2'b10
  } ei_stage_e;

  // Position of the lowest set bit; 0 when none is set.
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Mask of all bit positions below idx.
  function automatic logic [31:0] below_mask(input int unsigned idx);
    return (32'd1 << idx) - 32'd1;
  endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= req_i;
  end

  assign rise_o = req_i & ~prev_q;
endmodule

// File: rtl/irqc_master.sv
module irqc_master
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ei_i,
  input  logic di_i,
  input  logic reti_i,
  input  logic boundary_i,
  input  logic ack_i,
  output logic ime_o
);
  ei_stage_e stage_q;
  logic      ime_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ime_q   <= 1'b0;
      stage_q <= EI_IDLE;
    end else if (di_i || ack_i) begin
      ime_q   <= 1'b0;
      stage_q <= EI_IDLE;
    end else if (reti_i) begin
      ime_q   <= 1'b1;
      stage_q <= EI_IDLE;
    end else if (ei_i) begin
      stage_q <= boundary_i ? EI_WAIT_NEXT : EI_WAIT_OWN;
    end else if (boundary_i) begin
      case (stage_q)
        EI_WAIT_OWN:  stage_q <= EI_WAIT_NEXT;
        EI_WAIT_NEXT: begin
          ime_q   <= 1'b1;
          stage_q <= EI_IDLE;
        end
        default:      stage_q <= EI_IDLE;
      endcase
    end
  end

  assign ime_o = ime_q;

  a_r8_ack_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !ime_o);
  a_r4_di_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    di_i |=> !ime_o);
  a_r5_reti_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !di_i && !ack_i) |=> ime_o);
  a_r4_ei_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_i && !ime_o && !reti_i && !di_i && !ack_i) |=> !ime_o);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     serv_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |serv_i;
  assign idx_o = IDX_W'(lowest_set(32'(serv_i)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int          NUM_IRQ   = 5,
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [15:0] MASK_ADDR = 16'hFFFF,
  localparam int         IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int         PAD_W     = DATA_W - NUM_IRQ
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] req_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               cmd_ei_i,
  input  logic               cmd_di_i,
  input  logic               cmd_reti_i,
  input  logic               insn_done_i,
  input  logic               ack_i,
  output logic               irq_pending_o,
  output logic [IDX_W-1:0]   irq_index_o
);
  logic [NUM_IRQ-1:0] flags_q, mask_q, rise, serv, ack_clr, flags_d;
  logic               ime, any_serv, flag_wr, mask_wr, ack_take;

  irqc_edge #(.N(NUM_IRQ)) u_edge (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .rise_o(rise)
  );

  irqc_master u_master (
    .clk(clk), .rst_n(rst_n), .ei_i(cmd_ei_i), .di_i(cmd_di_i),
    .reti_i(cmd_reti_i), .boundary_i(insn_done_i), .ack_i(ack_i), .ime_o(ime)
  );

  assign serv = flags_q & mask_q;

  irqc_prio #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
    .serv_i(serv), .any_o(any_serv), .idx_o(irq_index_o)
  );

  assign irq_pending_o = ime & any_serv;
  assign flag_wr  = bus_wr_i && (bus_addr_i == ADDR_W'(FLAG_ADDR));
  assign mask_wr  = bus_wr_i && (bus_addr_i == ADDR_W'(MASK_ADDR));
  assign ack_take = ack_i && irq_pending_o;
  assign ack_clr  = ack_take ? (NUM_IRQ'(1) << irq_index_o) : '0;

  always_comb begin
    if (flag_wr) flags_d = bus_wdata_i[NUM_IRQ-1:0];
    else         flags_d = flags_q & ~ack_clr;
    flags_d = flags_d | rise;  // edge wins over any clear
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (mask_wr) mask_q <= bus_wdata_i[NUM_IRQ-1:0];
    end
  end

  always_comb begin
    if (bus_addr_i == ADDR_W'(FLAG_ADDR))
      bus_rdata_o = {{PAD_W{1'b1}}, flags_q};
    else if (bus_addr_i == ADDR_W'(MASK_ADDR))
      bus_rdata_o = {{PAD_W{1'b0}}, mask_q};
    else
      bus_rdata_o = '0;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_edge_chk
    a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> flags_q[g]);
  end

  a_r2_pending_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ime |-> !irq_pending_o);
  a_r3_lowest_chosen: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending_o |-> (serv[irq_index_o] &&
      ((32'(serv) & below_mask(32'(irq_index_o))) == 32'd0)));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rdata;
  logic        cmd_ei = 0, cmd_di = 0, cmd_reti = 0, insn_done = 0, ack = 0;
  logic        pend;
  logic [2:0]  idx;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_addr_i(bus_addr),
    .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
    .cmd_ei_i(cmd_ei), .cmd_di_i(cmd_di), .cmd_reti_i(cmd_reti),
    .insn_done_i(insn_done), .ack_i(ack), .irq_pending_o(pend),
    .irq_index_o(idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    bus_addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic cmd(input bit e, input bit d, input bit r, input bit b, input bit a);
    cmd_ei = e; cmd_di = d; cmd_reti = r; insn_done = b; ack = a;
    tick();
    cmd_ei = 0; cmd_di = 0; cmd_reti = 0; insn_done = 0; ack = 0;
  endtask

  task automatic clean();
    cmd(0, 1, 0, 0, 0);
    wr(16'hFF0F, 8'h00);
    wr(16'hFFFF, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(16'hFF0F, v); chk("R6 flags after reset", v, 8'hE0);
    rd(16'hFFFF, v); chk("R6 mask after reset", v, 8'h00);
    chk("R6 no pending after reset", pend, 0);
    wr(16'hFFFF, 8'h1F); wr(16'hFF0F, 8'h01);
    chk("R6 master enable starts at 0", pend, 0);
    clean();
  endtask

  task automatic t_edge();
    logic [7:0] v;
    req[2] = 1'b1; tick();
    rd(16'hFF0F, v); chk("R1 rising edge sets flag", v, 8'hE4);
    wr(16'hFF0F, 8'h00);
    repeat (3) tick();
    rd(16'hFF0F, v); chk("R1 held line does not re-set", v, 8'hE0);
    req[2] = 1'b0; tick();
    req[2] = 1'b1; tick();
    rd(16'hFF0F, v); chk("R1 new edge sets again", v, 8'hE4);
    req[2] = 1'b0;
    clean();
  endtask

  task automatic t_gate();
    logic [7:0] v;
    wr(16'hFF0F, 8'h02);
    cmd(0, 0, 1, 0, 0);
    chk("R2 masked request not pending", pend, 0);
    wr(16'hFFFF, 8'h02);
    chk("R2 enabled request pending", pend, 1);
    chk("R2 index of single request", idx, 1);
    cmd(0, 1, 0, 0, 0);
    chk("R2 master off blocks pending", pend, 0);
    rd(16'hFF0F, v); chk("R2 request stays latched", v, 8'hE2);
    clean();
  endtask

  task automatic t_prio();
    wr(16'hFF0F, 8'h1C); wr(16'hFFFF, 8'h1F);
    cmd(0, 0, 1, 0, 0);
    chk("R3 lowest of 2,3,4", idx, 2);
    wr(16'hFFFF, 8'h18);
    chk("R3 mask selects 3", idx, 3);
    wr(16'hFF0F, 8'h1F); wr(16'hFFFF, 8'h1F);
    chk("R3 bit 0 wins all", idx, 0);
    wr(16'hFF0F, 8'h10);
    chk("R3 only bit 4", idx, 4);
    clean();
  endtask

  task automatic t_ei_delay();
    wr(16'hFF0F, 8'h01); wr(16'hFFFF, 8'h01);
    cmd(1, 0, 0, 0, 0);
    chk("R4 no effect right after ei", pend, 0);
    cmd(0, 0, 0, 1, 0);
    chk("R4 no effect after ei boundary", pend, 0);
    cmd(0, 0, 0, 1, 0);
    chk("R4 effective after next insn", pend, 1);
    clean();
  endtask

  task automatic t_ei_di();
    wr(16'hFF0F, 8'h01); wr(16'hFFFF, 8'h01);
    cmd(1, 0, 0, 1, 0);
    chk("R4 ei with own boundary not yet", pend, 0);
    cmd(0, 1, 0, 1, 0);
    chk("R4 ei then di lets nothing through", pend, 0);
    cmd(0, 0, 0, 1, 0); cmd(0, 0, 0, 1, 0);
    chk("R4 cancelled enable stays off", pend, 0);
    clean();
  endtask

  task automatic t_reti();
    wr(16'hFF0F, 8'h08); wr(16'hFFFF, 8'h08);
    cmd(0, 0, 1, 0, 0);
    chk("R5 reti enables at once", pend, 1);
    clean();
  endtask

  task automatic t_ack();
    logic [7:0] v;
    wr(16'hFF0F, 8'h05); wr(16'hFFFF, 8'h1F);
    cmd(0, 0, 1, 0, 0);
    chk("R8 index before ack", idx, 0);
    cmd(0, 0, 0, 0, 1);
    chk("R8 ack clears master", pend, 0);
    rd(16'hFF0F, v); chk("R8 ack clears served bit", v, 8'hE4);
    cmd(0, 0, 1, 0, 0);
    chk("R8 next request after reti", idx, 2);
    clean();
  endtask

  task automatic t_write();
    wr(16'hFFFF, 8'h1F);
    cmd(0, 0, 1, 0, 0);
    wr(16'hFF0F, 8'h08);
    chk("R7 software raise pending", pend, 1);
    chk("R7 software raise index", idx, 3);
    wr(16'hFF0F, 8'h00);
    chk("R7 software discard", pend, 0);
    wr(16'hFFFF, 8'h00); wr(16'hFF0F, 8'h10);
    chk("R7 raised request still gated", pend, 0);
    clean();
  endtask

  task automatic t_race();
    logic [7:0] v;
    req[1] = 1'b1;
    wr(16'hFF0F, 8'h00);
    rd(16'hFF0F, v); chk("R9 edge beats write clear", v, 8'hE2);
    wr(16'hFFFF, 8'h02);
    cmd(0, 0, 1, 0, 0);
    chk("R9 pending before ack race", pend, 1);
    req[1] = 1'b0; tick();
    req[1] = 1'b1;
    cmd(0, 0, 0, 0, 1);
    rd(16'hFF0F, v); chk("R9 edge beats ack clear", v, 8'hE2);
    chk("R9 ack still drops master", pend, 0);
    req[1] = 1'b0;
    clean();
  endtask

  task automatic t_read();
    logic [7:0] v, a0, b0;
    wr(16'hFFFF, 8'hFF);
    rd(16'hFFFF, v); chk("R10 mask stores low bits only", v, 8'h1F);
    rd(16'h1234, v); chk("R10 unmapped address reads 0", v, 8'h00);
    wr(16'hFF0F, 8'hFF);
    rd(16'hFF0F, v); chk("R10 flag read pads ones", v, 8'hFF);
    cmd(0, 1, 0, 0, 0);
    rd(16'hFF0F, a0); rd(16'hFFFF, b0);
    cmd(0, 0, 1, 0, 0);
    rd(16'hFF0F, v); chk("R6 flag read hides master", v, a0);
    rd(16'hFFFF, v); chk("R6 mask read hides master", v, b0);
    clean();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_edge();
    t_gate();
    t_prio();
    t_ei_delay();
    t_ei_di();
    t_reti();
    t_ack();
    t_write();
    t_race();
    t_read();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule